// File: doc/BRIEF.md
# Ready-Latency Packet Transmit Framer

The framer accepts one packet at a time on a simple request port. A request carries the full header, up to four 32-bit dwords. The framer decodes the header size and the payload size from the first header dword. It then streams the header dwords and the payload dwords, packed back to back, onto a transmit bus made of valid, start-of-packet, end-of-packet and data signals. The bus width is a parameter of 64 or 128 bits. Payload dwords are not buffered inside the block. Instead, the framer publishes a dword index, and the attached payload store returns one bus-width window of payload that starts at that index, in the same cycle.

The downstream receiver grants transfer slots with a ready signal. That signal has a ready latency of 2 cycles by default, or 1 cycle as an option. A beat may be presented only in a cycle whose matching earlier ready was high. A beat that has no granted slot stays pending, unchanged, until a granted cycle arrives. After reset is released, the framer keeps the bus silent for a configurable number of cycles (2 by default), even when ready is already high.

Top module: `tx_framer`

## Requirements
- R1: With LANES = BUS_W/32, dword i of the stream travels in beat i/LANES, lane i%LANES, at bits [32*lane+31:32*lane]. The stream is the header dwords first, then the payload dwords.
  - Header dword k is taken from req_hdr[32k+31:32k].
  - Payload dword k is taken from pay_win lane (k - pay_base), where pay_base = max(0, beat*LANES - header dwords).
  - Lanes after the last dword of a packet carry zero.
- R2: The header is 4 dwords when bit 29 of header dword 0 is set, or when bits [28:27] equal 2'b10 (a message). Otherwise the header is 3 dwords.
- R3: When bit 30 of header dword 0 is clear, the payload is 0 dwords. When it is set, bits [9:0] give the payload dword count, and a value of 0 means 1024.
- R4: A packet occupies exactly ceil((header + payload dwords)/LANES) valid beats.
  - tx_sop is high on the first beat only, and tx_eop on the last beat only. A one-beat packet carries both.
  - Neither marker is ever high without tx_valid.
- R5: tx_valid is high in cycle t only if tx_ready was high in cycle t-READY_LAT (READY_LAT is 1 or 2).
- R6: In every cycle where a beat is pending, the quiet period is over, and tx_ready was high READY_LAT cycles earlier, tx_valid is high.
- R7: A beat that is not granted keeps its data, tx_sop and tx_eop unchanged until it is sent in the next granted cycle.
- R8: tx_valid stays low for the first QUIET_CYC cycles after reset is released. The first of those cycles is the one in which rst_n is first seen high.
- R9: req_ready is high exactly when no packet is in flight. A request is taken when req_valid and req_ready are both high at a clock edge. req_ready then stays low through the cycle that carries that packet's last beat.
- R10: While rst_n is low, tx_valid, tx_sop and tx_eop are low and req_ready is high. No request is taken while reset is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request holds a packet header |
| req_ready | output | 1 | Framer idle, request can be taken |
| req_hdr | input | 128 | Header dwords; dword 0 in bits [31:0] |
| pay_base | output | 11 | Payload dword index of lane 0 of pay_win |
| pay_win | input | BUS_W | Payload dwords pay_base onward, one per lane |
| tx_valid | output | 1 | Beat present on the transmit bus |
| tx_sop | output | 1 | First beat of a packet |
| tx_eop | output | 1 | Last beat of a packet |
| tx_data | output | BUS_W | Beat data |
| tx_ready | input | 1 | Slot grant, effective READY_LAT cycles later |

## Verification
Several rules are checked by assertions on every cycle:
- the grant rule of R5;
- the post-reset silence of R8;
- the start and end marker sequence, and the beat count matched against the decoded header, from R4;
- the hold of an ungranted beat from R7;
- the idle and busy handshake from R9.

Some behaviour can only be shown by the bench scenarios, which compare against a behavioural model on every cycle. This covers the packing of dwords into lanes, including payload fetched through the window index (R1). It covers header and payload size decoding, including messages and the 1024-dword encoding (R2, R3). It also covers the rule that no granted slot is wasted (R6), under steady, alternating, bursty and pseudo-random ready patterns.

// File: rtl/tx_framer_pkg.sv
// Package: shared constants and header decode helpers for the transmit framer.
// Assumes header dword 0 carries the data flag in bit 30, the four-dword flag
// in bit 29, the upper type bits in [28:27] and the payload length in [9:0].
package tx_framer_pkg;

    localparam int DWORD_W  = 32;
    localparam int HDR_MAX  = 4;
    localparam int LEN_W    = 10;
    localparam int PAY_MAX  = 1 << LEN_W;
    localparam int DW_MAX   = HDR_MAX + PAY_MAX;

    // Header size in dwords: four when flagged or when the packet is a message.
    function automatic logic [2:0] hdr_dwords(input logic four_flag, input logic [1:0] ty_hi);
        return (four_flag || (ty_hi == 2'b10)) ? 3'd4 : 3'd3;
    endfunction

    // Payload size in dwords: zero without data, a length of zero means the maximum.
    function automatic logic [LEN_W:0] pay_dwords(input logic has_data, input logic [LEN_W-1:0] len);
        if (!has_data)
            return '0;
        else if (len == '0)
            return (LEN_W+1)'(PAY_MAX);
        else
            return {1'b0, len};
    endfunction

endpackage

// File: rtl/tx_rl_gate.sv
// Module: tx_rl_gate
// Turns the downstream ready into a per-cycle transfer grant. Ready is delayed
// by READY_LAT cycles, and no grant is given during the quiet window that
// follows reset release.
// Assumes READY_LAT is 1 or 2 and that reset is synchronous and active low.
module tx_rl_gate #(
    parameter int READY_LAT = 2,
    parameter int QUIET_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_ready,
    output logic permit
);

    localparam int QC_W = $clog2(QUIET_CYC + 2);

    logic [READY_LAT-1:0] rdy_sr;
    logic [QC_W-1:0]      quiet_cnt;
    logic                 quiet_done;

    // Shift register: delays ready by the configured latency.
    generate
        if (READY_LAT == 1) begin : g_rl_one
            always_ff @(posedge clk) begin
                if (!rst_n) rdy_sr <= '0;
                else        rdy_sr <= tx_ready;
            end
        end else begin : g_rl_many
            always_ff @(posedge clk) begin
                if (!rst_n) rdy_sr <= '0;
                else        rdy_sr <= {rdy_sr[READY_LAT-2:0], tx_ready};
            end
        end
    endgenerate

    // Quiet counter: counts cycles after reset until the silence window ends.
    always_ff @(posedge clk) begin
        if (!rst_n)
            quiet_cnt <= '0;
        else if (!quiet_done)
            quiet_cnt <= quiet_cnt + QC_W'(1);
    end

    assign quiet_done = (int'(quiet_cnt) >= QUIET_CYC);
    assign permit     = rdy_sr[READY_LAT-1] && quiet_done;

    // R5: a grant always traces back to ready at the configured latency.
    generate
        if (READY_LAT == 1) begin : g_chk_rl1
            a_r5_grant_latency: assert property (@(posedge clk) disable iff (!rst_n)
                permit |-> $past(tx_ready, 1));
        end else if (READY_LAT == 2) begin : g_chk_rl2
            a_r5_grant_latency: assert property (@(posedge clk) disable iff (!rst_n)
                permit |-> $past(tx_ready, 2));
        end
    endgenerate

endmodule

// File: rtl/tx_beat_ctrl.sv
// Module: tx_beat_ctrl
// Takes one request while idle and decodes its header size and total dword
// count. It then walks the beat index, advancing only on granted cycles.
// Assumes the header is stable while req_valid is high, and that a packet
// never exceeds the decoded dword count.
module tx_beat_ctrl
    import tx_framer_pkg::*;
#(
    parameter int LANES  = 2,
    parameter int BEAT_W = 10,
    parameter int DWC_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [127:0]      req_hdr,
    input  logic              permit,
    output logic              req_ready,
    output logic              busy,
    output logic              fire,
    output logic              first_beat,
    output logic              last_beat,
    output logic [BEAT_W-1:0] beat_idx,
    output logic [127:0]      hdr_q,
    output logic [2:0]        hdr_dw,
    output logic [DWC_W-1:0]  tot_dw
);

    localparam int LANE_LG = $clog2(LANES);

    logic [2:0]        h_new;
    logic [LEN_W:0]    p_new;
    logic [DWC_W-1:0]  t_new;
    logic [BEAT_W-1:0] last_new;
    logic [BEAT_W-1:0] last_idx;

    // Header decode: sizes and last beat index of the request on offer.
    always_comb begin
        h_new    = hdr_dwords(req_hdr[29], req_hdr[28:27]);
        p_new    = pay_dwords(req_hdr[30], req_hdr[LEN_W-1:0]);
        t_new    = DWC_W'(h_new) + DWC_W'(p_new);
        last_new = BEAT_W'((t_new + DWC_W'(LANES - 1)) >> LANE_LG) - BEAT_W'(1);
    end

    // Packet state: capture on accept, step the beat index on each grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            beat_idx <= '0;
            last_idx <= '0;
            hdr_q    <= '0;
            hdr_dw   <= 3'd3;
            tot_dw   <= '0;
        end else if (!busy) begin
            if (req_valid) begin
                busy     <= 1'b1;
                beat_idx <= '0;
                last_idx <= last_new;
                hdr_q    <= req_hdr;
                hdr_dw   <= h_new;
                tot_dw   <= t_new;
            end
        end else if (fire) begin
            if (beat_idx == last_idx) busy <= 1'b0;
            else                      beat_idx <= beat_idx + BEAT_W'(1);
        end
    end

    assign req_ready  = !busy;
    assign fire       = busy && permit;
    assign first_beat = (beat_idx == '0);
    assign last_beat  = (beat_idx == last_idx);

    // R7: an ungranted beat keeps its position and the packet stays open.
    a_r7_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !permit |=> busy && $stable(beat_idx));

    // R9: the packet closes only right after its last beat was granted.
    a_r9_close_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(fire) && $past(beat_idx == last_idx));

endmodule

// File: rtl/tx_lane_mux.sv
// Module: tx_lane_mux
// Builds the data of the current beat. Each lane selects a header dword, a
// payload dword from the external window, or zero past the end of the packet.
// It also publishes the payload index the window must start at.
// Assumes the window returns dwords pay_base onward in the same cycle.
module tx_lane_mux #(
    parameter int LANES  = 2,
    parameter int BEAT_W = 10,
    parameter int DWC_W  = 11
) (
    input  logic                  valid,
    input  logic [BEAT_W-1:0]     beat_idx,
    input  logic [127:0]          hdr_q,
    input  logic [2:0]            hdr_dw,
    input  logic [DWC_W-1:0]      tot_dw,
    input  logic [LANES*32-1:0]   pay_win,
    output logic [DWC_W-1:0]      pay_base,
    output logic [LANES*32-1:0]   data
);

    localparam int LANE_LG = $clog2(LANES);

    int base_i;

    // Window index: payload dword that lands in lane 0 of this beat.
    always_comb begin
        base_i   = int'(beat_idx) * LANES - int'(hdr_dw);
        if (base_i < 0) base_i = 0;
        pay_base = DWC_W'(base_i);
    end

    generate
        for (genvar j = 0; j < LANES; j++) begin : g_lane
            logic [31:0]        lane_dw;
            logic [LANE_LG-1:0] win_sel;
            int                 s_i;
            int                 off_i;

            // Lane select: header, payload window or zero fill for lane j.
            always_comb begin
                s_i     = int'(beat_idx) * LANES + j;
                off_i   = s_i - int'(hdr_dw) - base_i;
                win_sel = LANE_LG'(off_i);
                if (!valid)
                    lane_dw = '0;
                else if (s_i < int'(hdr_dw))
                    lane_dw = hdr_q[{s_i[1:0], 5'b0} +: 32];
                else if (s_i < int'(tot_dw))
                    lane_dw = pay_win[{win_sel, 5'b0} +: 32];
                else
                    lane_dw = '0;
            end

            assign data[32*j +: 32] = lane_dw;
        end
    endgenerate

endmodule

// File: rtl/tx_framer.sv
// Module: tx_framer (top)
// Frames one packet at a time onto a ready-latency streaming transmit bus.
// It combines the grant gate, the beat controller and the lane builder, and
// holds the protocol assertions on its ports.
// Assumes BUS_W is 64 or 128 and READY_LAT is 1 or 2.
module tx_framer
    import tx_framer_pkg::*;
#(
    parameter int BUS_W     = 64,
    parameter int READY_LAT = 2,
    parameter int QUIET_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [127:0]     req_hdr,
    output logic [10:0]      pay_base,
    input  logic [BUS_W-1:0] pay_win,
    output logic             tx_valid,
    output logic             tx_sop,
    output logic             tx_eop,
    output logic [BUS_W-1:0] tx_data,
    input  logic             tx_ready
);

    localparam int LANES     = BUS_W / DWORD_W;
    localparam int MAX_BEATS = (DW_MAX + LANES - 1) / LANES;
    localparam int BEAT_W    = $clog2(MAX_BEATS + 1);
    localparam int DWC_W     = $clog2(DW_MAX + 1);
    localparam int QC_W      = $clog2(QUIET_CYC + 2);

    logic              permit;
    logic              busy;
    logic              fire;
    logic              first_beat;
    logic              last_beat;
    logic [BEAT_W-1:0] beat_idx;
    logic [127:0]      hdr_q;
    logic [2:0]        hdr_dw;
    logic [DWC_W-1:0]  tot_dw;
    logic [DWC_W-1:0]  base_w;

    tx_rl_gate #(
        .READY_LAT (READY_LAT),
        .QUIET_CYC (QUIET_CYC)
    ) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_ready (tx_ready),
        .permit   (permit)
    );

    tx_beat_ctrl #(
        .LANES  (LANES),
        .BEAT_W (BEAT_W),
        .DWC_W  (DWC_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_hdr    (req_hdr),
        .permit     (permit),
        .req_ready  (req_ready),
        .busy       (busy),
        .fire       (fire),
        .first_beat (first_beat),
        .last_beat  (last_beat),
        .beat_idx   (beat_idx),
        .hdr_q      (hdr_q),
        .hdr_dw     (hdr_dw),
        .tot_dw     (tot_dw)
    );

    tx_lane_mux #(
        .LANES  (LANES),
        .BEAT_W (BEAT_W),
        .DWC_W  (DWC_W)
    ) u_mux (
        .valid    (fire),
        .beat_idx (beat_idx),
        .hdr_q    (hdr_q),
        .hdr_dw   (hdr_dw),
        .tot_dw   (tot_dw),
        .pay_win  (pay_win),
        .pay_base (base_w),
        .data     (tx_data)
    );

    assign pay_base = 11'(base_w);
    assign tx_valid = fire;
    assign tx_sop   = fire && first_beat;
    assign tx_eop   = fire && last_beat;

    // Port-level protocol checking: independent counters beside the datapath.
    logic [QC_W-1:0]   chk_since;
    logic              chk_open;
    logic [BEAT_W-1:0] chk_beats;
    logic [BEAT_W-1:0] chk_expect;

    // Cycle counter since reset release, saturating at the quiet length.
    always_ff @(posedge clk) begin
        if (!rst_n)
            chk_since <= '0;
        else if (int'(chk_since) < QUIET_CYC)
            chk_since <= chk_since + QC_W'(1);
    end

    // Packet tracker: open flag, beats seen and beats owed per the header.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_open   <= 1'b0;
            chk_beats  <= '0;
            chk_expect <= '0;
        end else begin
            if (req_valid && req_ready)
                chk_expect <= BEAT_W'((int'(hdr_dwords(req_hdr[29], req_hdr[28:27]))
                              + int'(pay_dwords(req_hdr[30], req_hdr[LEN_W-1:0]))
                              + LANES - 1) / LANES);
            if (tx_valid) begin
                if (tx_eop) begin
                    chk_open  <= 1'b0;
                    chk_beats <= '0;
                end else begin
                    chk_open  <= 1'b1;
                    chk_beats <= chk_beats + BEAT_W'(1);
                end
            end
        end
    end

    // R8: the bus stays silent during the quiet window after reset.
    a_r8_quiet_window: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(chk_since) < QUIET_CYC) |-> !tx_valid);

    // R4: a beat outside an open packet must start one.
    a_r4_sop_opens: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !chk_open |-> tx_sop);

    // R4: no second start marker inside an open packet.
    a_r4_no_dup_sop: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && chk_open |-> !tx_sop);

    // R4: the end marker arrives exactly on the beat count the header implies.
    a_r4_beat_count: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_eop |-> (int'(chk_beats) + 1 == int'(chk_expect)));

    // R4: markers never appear without valid.
    a_r4_markers_need_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_sop || tx_eop) |-> tx_valid);

    // R9: a taken request closes the request port on the next cycle.
    a_r9_take_closes: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

endmodule

// File: tb/sim_tx_framer.sv
// Bench: behavioural cycle model (queues of expected beats, ready history)
// compared with the framer outputs on every cycle.
module sim_tx_framer;

    localparam int BUS_W = 64;
    localparam int LANES = BUS_W / 32;
    localparam int RL    = 2;
    localparam int QUIET = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [127:0]     req_hdr = '0;
    logic [10:0]      pay_base;
    logic [BUS_W-1:0] pay_win;
    logic             tx_valid;
    logic             tx_sop;
    logic             tx_eop;
    logic [BUS_W-1:0] tx_data;
    logic             tx_ready = 1'b0;

    always #4 clk = ~clk;

    tx_framer #(
        .BUS_W     (BUS_W),
        .READY_LAT (RL),
        .QUIET_CYC (QUIET)
    ) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_hdr   (req_hdr),
        .pay_base  (pay_base),
        .pay_win   (pay_win),
        .tx_valid  (tx_valid),
        .tx_sop    (tx_sop),
        .tx_eop    (tx_eop),
        .tx_data   (tx_data),
        .tx_ready  (tx_ready)
    );

    int cur_seq = 0;

    function automatic logic [31:0] pd(input int s, input int k);
        return {8'(s), 8'h5A, 16'(k)};
    endfunction

    // Payload store: returns dwords pay_base onward for the current packet.
    always_comb begin
        for (int j = 0; j < LANES; j++)
            pay_win[32*j +: 32] = pd(cur_seq, int'(pay_base) + j);
    end

    logic [BUS_W-1:0] q_data[$];
    bit               q_sop[$];
    bit               q_eop[$];
    int               q_nbeats[$];
    bit               rlog[$];
    logic [127:0]     pkt_q[$];
    int               cyc = 0;
    int               n_chk = 0;
    int               n_bad = 0;
    int               rmode = 0;
    logic [15:0]      lfsr = 16'hACE1;
    int               dut_beats = 0;
    bit               wd = 1'b0;

    task automatic check(input bit ok, input string msg);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s", msg);
        end
    endtask

    function automatic logic [127:0] mk(input bit d, input bit f4, input logic [4:0] ty,
                                        input logic [9:0] len, input int tag);
        logic [31:0] dw0;
        dw0 = {1'b0, d, f4, ty, 14'h0, len};
        return {32'hC300_0000 + 32'(tag), 32'hB200_0000 + 32'(tag),
                32'hA100_0000 + 32'(tag), dw0};
    endfunction

    // Expected beats of one packet, derived from R1, R2, R3 and R4.
    task automatic build(input logic [127:0] h, input int s);
        int hd;
        int pl;
        int tot;
        int nb;
        hd  = (h[29] || h[28:27] == 2'b10) ? 4 : 3;
        pl  = !h[30] ? 0 : ((h[9:0] == 10'd0) ? 1024 : int'(h[9:0]));
        tot = hd + pl;
        nb  = (tot + LANES - 1) / LANES;
        for (int b = 0; b < nb; b++) begin
            logic [BUS_W-1:0] d;
            d = '0;
            for (int j = 0; j < LANES; j++) begin
                int i;
                i = b * LANES + j;
                if (i < hd)       d[32*j +: 32] = h[32*i +: 32];
                else if (i < tot) d[32*j +: 32] = pd(s, i - hd);
            end
            q_data.push_back(d);
            q_sop.push_back(b == 0);
            q_eop.push_back(b == nb - 1);
        end
        q_nbeats.push_back(nb);
    endtask

    function automatic bit rdy_fn();
        case (rmode)
            0:       return 1'b1;
            1:       return cyc[0];
            2:       return lfsr[0];
            3:       return (cyc % 7) < 3;
            default: return 1'b0;
        endcase
    endfunction

    // One clock cycle: drive inputs, compare outputs, advance the model.
    task automatic step();
        bit ev;
        bit er;
        int s;
        @(negedge clk);
        rst_n     = 1'b1;
        lfsr      = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        tx_ready  = rdy_fn();
        req_valid = (pkt_q.size() > 0);
        req_hdr   = (pkt_q.size() > 0) ? pkt_q[0] : '0;
        #1;
        er = (q_data.size() == 0);
        ev = (q_data.size() > 0) && (cyc >= QUIET) && (cyc >= RL) && rlog[cyc - RL];
        if (cyc < QUIET)
            check(tx_valid == 1'b0, $sformatf("R8 quiet cyc=%0d tx_valid act=%0b exp=0", cyc, tx_valid));
        check(tx_valid == ev, $sformatf("R5/R6 cyc=%0d tx_valid act=%0b exp=%0b", cyc, tx_valid, ev));
        check(req_ready == er, $sformatf("R9 cyc=%0d req_ready act=%0b exp=%0b", cyc, req_ready, er));
        if (ev && tx_valid) begin
            check(tx_data == q_data[0], $sformatf("R1/R7 cyc=%0d data act=%h exp=%h", cyc, tx_data, q_data[0]));
            check(tx_sop == q_sop[0] && tx_eop == q_eop[0],
                  $sformatf("R4 cyc=%0d sop/eop act=%0b%0b exp=%0b%0b", cyc, tx_sop, tx_eop, q_sop[0], q_eop[0]));
        end else begin
            check(!tx_sop && !tx_eop, $sformatf("R4 cyc=%0d idle markers act=%0b%0b exp=00", cyc, tx_sop, tx_eop));
        end
        if (tx_valid) begin
            dut_beats++;
            if (tx_eop) begin
                if (q_nbeats.size() == 0) begin
                    check(1'b0, $sformatf("R2/R3/R4 cyc=%0d beats act=%0d exp=none", cyc, dut_beats));
                end else begin
                    check(dut_beats == q_nbeats[0],
                          $sformatf("R2/R3/R4 cyc=%0d beats act=%0d exp=%0d", cyc, dut_beats, q_nbeats[0]));
                    void'(q_nbeats.pop_front());
                end
                dut_beats = 0;
            end
        end
        rlog.push_back(tx_ready);
        if (ev) begin
            void'(q_data.pop_front());
            void'(q_sop.pop_front());
            void'(q_eop.pop_front());
        end
        if (req_valid && er) begin
            s = cur_seq + 1;
            build(pkt_q.pop_front(), s);
            cur_seq = s;
        end
        cyc++;
        if (cyc > 150000) wd = 1'b1;
    endtask

    task automatic run_idle();
        while ((pkt_q.size() > 0 || q_data.size() > 0) && !wd) step();
        for (int i = 0; i < 4; i++) step();
    endtask

    task automatic load_set(input int tag);
        pkt_q.push_back(mk(1'b0, 1'b0, 5'h00, 10'd0, tag));      // 3 dw, no data
        pkt_q.push_back(mk(1'b0, 1'b1, 5'h00, 10'd0, tag + 1));  // 4 dw, no data (R2)
        pkt_q.push_back(mk(1'b1, 1'b0, 5'h00, 10'd1, tag + 2));  // 3+1 dw
        pkt_q.push_back(mk(1'b1, 1'b1, 5'h00, 10'd1, tag + 3));  // 4+1 dw
        pkt_q.push_back(mk(1'b1, 1'b0, 5'h10, 10'd2, tag + 4));  // message: 4+2 dw (R2)
        pkt_q.push_back(mk(1'b1, 1'b0, 5'h00, 10'd5, tag + 5));  // 3+5 dw
        pkt_q.push_back(mk(1'b0, 1'b0, 5'h00, 10'd9, tag + 6));  // length ignored without data (R3)
        pkt_q.push_back(mk(1'b1, 1'b1, 5'h00, 10'd3, tag + 7));  // 4+3 dw
    endtask

    initial begin
        // R10: reset state with ready already high.
        rst_n    = 1'b0;
        tx_ready = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            req_valid = 1'b1;
            req_hdr   = mk(1'b1, 1'b0, 5'h00, 10'd1, 99);
            #1;
            check(!tx_valid && !tx_sop && !tx_eop,
                  $sformatf("R10 reset outputs act=%0b%0b%0b exp=000", tx_valid, tx_sop, tx_eop));
            check(req_ready == 1'b1, $sformatf("R10 reset req_ready act=%0b exp=1", req_ready));
        end
        req_valid = 1'b0;
        // R8: a packet waits at release with ready high.
        rmode = 0;
        load_set(16);
        run_idle();
        rmode = 1;
        load_set(32);
        run_idle();
        rmode = 2;
        load_set(48);
        run_idle();
        rmode = 3;
        load_set(64);
        run_idle();
        // R3: zero length with data means 1024 payload dwords.
        rmode = 2;
        pkt_q.push_back(mk(1'b1, 1'b0, 5'h00, 10'd0, 80));
        pkt_q.push_back(mk(1'b1, 1'b1, 5'h00, 10'd0, 81));
        run_idle();
        if (wd) check(1'b0, $sformatf("watchdog cyc act=%0d exp<150000", cyc));
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule